// File: doc/BRIEF.md
# SPI Register Access Slave

This block sits behind an SPI mode 0 link and lets an external host read and write 32-bit words in a 16-bit-addressed register space. Each transaction opens with an opcode byte and a two-byte address. A read then returns four data bytes to the host. A write takes four data bytes from the host. The SPI pins are oversampled by the system clock, so the whole block runs in one clock domain.

Two addresses are answered locally and are never passed on. The first is a test word whose fixed pattern lets the host confirm byte order and link health. The second is a configuration word that reports whether the device is ready. All other reads and writes go out over a simple strobed parallel port.

The host must hold SCLK high and low for at least SYNC_STAGES + 6 clock cycles in each phase. With the defaults that is 8 cycles.

Top module: `spireg_slave`

## Requirements
- R1: After reset, `spi_miso`, `reg_rd` and `reg_wr` are all 0.
- R2: Opcode 0x03 is a read. It is followed by two address bytes, most significant byte first. The slave then returns four data bytes: bits 7:0 first and bits 31:24 last. Within each byte the MSB goes first. MOSI is sampled on the SCLK rising edge and MISO changes after the falling edge.
- R3: A read of address 0x0064 returns 0x87654321 and raises no `reg_rd`.
- R4: A read of address 0x0074 returns a word in which bit 27 equals `dev_ready` and every other bit is 0. It raises no `reg_rd`.
- R5: A read of any other address raises `reg_rd` for exactly one cycle, with `reg_addr` holding the address. `reg_rdata` is sampled in the cycle after that pulse and is returned to the host.
- R6: Opcode 0x02 is a write. Once the fourth data byte has arrived, `reg_wr` pulses for one cycle. During that cycle `reg_addr` holds the address and `reg_wdata` holds the data, with the first data byte in bits 7:0.
- R7: A write to 0x0064 or 0x0074 raises no `reg_wr`.
- R8: Any other opcode makes the slave ignore the rest of the frame: no strobe, and MISO stays 0.
- R9: If chip select is released before a write is complete, nothing is committed. The next frame starts again from its opcode byte.
- R10: Bytes after the seventh in a frame are ignored. No extra strobe is raised, and MISO reads 0 during them.
- R11: MISO falls to 0 within SYNC_STAGES + 1 cycles after chip select is released, and stays 0 while chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock from the host |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| dev_ready | input | 1 | Readiness flag reported in the configuration word |
| reg_addr | output | 16 | Address on the internal port |
| reg_rd | output | 1 | One-cycle read request |
| reg_rdata | input | 32 | Read data, valid the cycle after `reg_rd` |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 32 | Write data, valid with `reg_wr` |

## Verification
The bench builds the block with its default parameters: a two-stage pin synchronizer and the test and configuration words at 0x0064 and 0x0074. It drives SCLK with an 8-cycle half period, which is the smallest phase these defaults allow. This puts the forwarded-read path at its tightest point: the internal read data has to reach the shift register before the first falling edge of the data phase. The default addresses make the local-versus-forwarded decode and the dropped writes directly observable.

// File: rtl/spireg_pkg.sv
package spireg_pkg;

    localparam int ADDR_W      = 16;
    localparam int DATA_W      = 32;
    localparam int ADDR_BYTES  = ADDR_W / 8;
    localparam int DATA_BYTES  = DATA_W / 8;
    localparam int FRAME_BYTES = 1 + ADDR_BYTES + DATA_BYTES;
    localparam int IDX_W       = $clog2(FRAME_BYTES + 1) + 1;

    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_WRITE = 8'h02;

    localparam logic [ADDR_W-1:0] DEF_TEST_ADDR = 16'h0064;
    localparam logic [ADDR_W-1:0] DEF_CFG_ADDR  = 16'h0074;
    localparam logic [DATA_W-1:0] DEF_TEST_WORD = 32'h8765_4321;
    localparam int                DEF_READY_BIT = 27;

    typedef enum logic [2:0] {
        PH_CMD,
        PH_ADDR,
        PH_WDATA,
        PH_RDATA,
        PH_IGNORE
    } phase_e;

    typedef enum logic [1:0] {
        SRC_TEST,
        SRC_CFG,
        SRC_PORT
    } rsrc_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } xfer_t;

    // Reorders a word so that byte 0 leaves first when shifted MSB-first.
    function automatic logic [DATA_W-1:0] to_serial(logic [DATA_W-1:0] w);
        logic [DATA_W-1:0] s;
        for (int k = 0; k < DATA_BYTES; k++) begin
            s[8*(DATA_BYTES-1-k) +: 8] = w[8*k +: 8];
        end
        return s;
    endfunction

endpackage

// File: rtl/spireg_sync.sv
module spireg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_in,
    input  logic cs_n_in,
    input  logic mosi_in,
    output logic sclk_s,
    output logic cs_n_s,
    output logic mosi_s
);
    localparam int         LANES   = 3;
    localparam logic [2:0] RST_VAL = 3'b010;

    logic [LANES-1:0] raw;
    logic [LANES-1:0] synced;

    assign raw = {mosi_in, cs_n_in, sclk_in};

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [STAGES-1:0] pipe;
        always_ff @(posedge clk) begin
            if (rst) pipe <= {STAGES{RST_VAL[i]}};
            else     pipe <= {pipe[STAGES-2:0], raw[i]};
        end
        assign synced[i] = pipe[STAGES-1];
    end

    assign sclk_s = synced[0];
    assign cs_n_s = synced[1];
    assign mosi_s = synced[2];
endmodule

// File: rtl/spireg_rx.sv
module spireg_rx
    import spireg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sclk_s,
    input  logic             cs_n_s,
    input  logic             mosi_s,
    output logic             fall,
    output logic             byte_valid,
    output logic [7:0]       rx_byte,
    output logic [IDX_W-1:0] byte_idx
);
    localparam logic [IDX_W-1:0] IDX_MAX = '1;

    logic             sclk_q;
    logic             rise;
    logic [2:0]       bit_cnt;
    logic [6:0]       shreg;
    logic [IDX_W-1:0] byte_cnt;

    assign rise = sclk_s & ~sclk_q & ~cs_n_s;
    assign fall = ~sclk_s & sclk_q & ~cs_n_s;

    always_ff @(posedge clk) begin
        if (rst) sclk_q <= 1'b0;
        else     sclk_q <= sclk_s;
    end

    always_ff @(posedge clk) begin
        if (rst || cs_n_s) begin
            bit_cnt    <= '0;
            shreg      <= '0;
            byte_cnt   <= '0;
            byte_valid <= 1'b0;
            rx_byte    <= '0;
            byte_idx   <= '0;
        end else begin
            byte_valid <= 1'b0;
            if (rise) begin
                shreg   <= {shreg[5:0], mosi_s};
                bit_cnt <= bit_cnt + 3'd1;
                if (bit_cnt == 3'd7) begin
                    byte_valid <= 1'b1;
                    rx_byte    <= {shreg, mosi_s};
                    byte_idx   <= byte_cnt;
                    if (byte_cnt != IDX_MAX) byte_cnt <= byte_cnt + 1'b1;
                end
            end
        end
    end

    // Bytes need eight rising edges each, so two completions never abut.
    assert_byte_gap_R2: assert property (@(posedge clk) disable iff (rst)
        byte_valid |=> !byte_valid);
endmodule

// File: rtl/spireg_tx.sv
module spireg_tx
    import spireg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n_s,
    input  logic              fall,
    input  logic              load,
    input  logic [DATA_W-1:0] load_word,
    output logic              miso
);
    logic [DATA_W-1:0] sreg;
    logic              active;
    logic              skip;

    always_ff @(posedge clk) begin
        if (rst || cs_n_s) begin
            sreg   <= '0;
            active <= 1'b0;
            skip   <= 1'b0;
        end else if (load) begin
            sreg   <= to_serial(load_word);
            active <= 1'b1;
            skip   <= 1'b1;
        end else if (fall && active) begin
            if (skip) skip <= 1'b0;
            else      sreg <= {sreg[DATA_W-2:0], 1'b0};
        end
    end

    assign miso = active & sreg[DATA_W-1];

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        cs_n_s |=> !miso);
endmodule

// File: rtl/spireg_ctrl.sv
module spireg_ctrl
    import spireg_pkg::*;
#(
    parameter logic [ADDR_W-1:0] TEST_ADDR = DEF_TEST_ADDR,
    parameter logic [ADDR_W-1:0] CFG_ADDR  = DEF_CFG_ADDR,
    parameter logic [DATA_W-1:0] TEST_WORD = DEF_TEST_WORD,
    parameter int                READY_BIT = DEF_READY_BIT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n_s,
    input  logic              byte_valid,
    input  logic [7:0]        rx_byte,
    input  logic [IDX_W-1:0]  byte_idx,
    input  logic              ready,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_rd,
    output logic              reg_wr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              tx_load,
    output logic [DATA_W-1:0] tx_word
);
    localparam logic [IDX_W-1:0] LAST_ADDR_IDX  = IDX_W'(ADDR_BYTES);
    localparam logic [IDX_W-1:0] FIRST_DATA_IDX = IDX_W'(ADDR_BYTES + 1);
    localparam logic [IDX_W-1:0] LAST_DATA_IDX  = IDX_W'(FRAME_BYTES - 1);

    phase_e            phase;
    logic              is_read;
    xfer_t             cur;
    rsrc_e             src;
    logic              pend1, pend2;
    logic [ADDR_W-1:0] next_addr;
    logic [IDX_W-1:0]  dpos;
    logic [DATA_W-1:0] cfg_word;

    function automatic logic fixed_addr(logic [ADDR_W-1:0] a);
        return (a == TEST_ADDR) || (a == CFG_ADDR);
    endfunction

    assign next_addr = {cur.addr[ADDR_W-9:0], rx_byte};
    assign dpos      = byte_idx - FIRST_DATA_IDX;

    always_ff @(posedge clk) begin
        if (rst || cs_n_s) begin
            phase   <= PH_CMD;
            is_read <= 1'b0;
            cur     <= '0;
            src     <= SRC_PORT;
            pend1   <= 1'b0;
            pend2   <= 1'b0;
            reg_rd  <= 1'b0;
            reg_wr  <= 1'b0;
        end else begin
            reg_rd <= 1'b0;
            reg_wr <= 1'b0;
            pend1  <= 1'b0;
            pend2  <= pend1;
            if (byte_valid) begin
                unique case (phase)
                    PH_CMD: begin
                        if (rx_byte == OP_READ) begin
                            is_read <= 1'b1;
                            phase   <= PH_ADDR;
                        end else if (rx_byte == OP_WRITE) begin
                            is_read <= 1'b0;
                            phase   <= PH_ADDR;
                        end else begin
                            phase   <= PH_IGNORE;
                        end
                    end
                    PH_ADDR: begin
                        cur.addr <= next_addr;
                        if (byte_idx == LAST_ADDR_IDX) begin
                            if (is_read) begin
                                phase <= PH_RDATA;
                                pend1 <= 1'b1;
                                if (next_addr == TEST_ADDR)     src <= SRC_TEST;
                                else if (next_addr == CFG_ADDR) src <= SRC_CFG;
                                else begin
                                    src    <= SRC_PORT;
                                    reg_rd <= 1'b1;
                                end
                            end else begin
                                phase <= PH_WDATA;
                            end
                        end
                    end
                    PH_WDATA: begin
                        for (int k = 0; k < DATA_BYTES; k++) begin
                            if (dpos == IDX_W'(k)) cur.data[8*k +: 8] <= rx_byte;
                        end
                        if (byte_idx == LAST_DATA_IDX) begin
                            reg_wr <= !fixed_addr(cur.addr);
                            phase  <= PH_IGNORE;
                        end
                    end
                    PH_RDATA, PH_IGNORE: ;
                    default: phase <= PH_IGNORE;
                endcase
            end
        end
    end

    always_comb begin
        cfg_word            = '0;
        cfg_word[READY_BIT] = ready;
        unique case (src)
            SRC_TEST: tx_word = TEST_WORD;
            SRC_CFG:  tx_word = cfg_word;
            default:  tx_word = reg_rdata;
        endcase
    end

    assign tx_load   = pend2;
    assign reg_addr  = cur.addr;
    assign reg_wdata = cur.data;

    assert_wr_single_R6: assert property (@(posedge clk) disable iff (rst)
        reg_wr |=> !reg_wr);
    assert_wr_not_fixed_R7: assert property (@(posedge clk) disable iff (rst)
        reg_wr |-> !fixed_addr(reg_addr));
    assert_rd_not_fixed_R3: assert property (@(posedge clk) disable iff (rst)
        reg_rd |-> !fixed_addr(reg_addr));
    assert_rd_wr_apart_R5: assert property (@(posedge clk) disable iff (rst)
        !(reg_rd && reg_wr));
    assert_abort_R9: assert property (@(posedge clk) disable iff (rst)
        cs_n_s |=> !reg_wr);
endmodule

// File: rtl/spireg_slave.sv
module spireg_slave
    import spireg_pkg::*;
#(
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] TEST_ADDR   = DEF_TEST_ADDR,
    parameter logic [ADDR_W-1:0] CFG_ADDR    = DEF_CFG_ADDR,
    parameter logic [DATA_W-1:0] TEST_WORD   = DEF_TEST_WORD,
    parameter int                READY_BIT   = DEF_READY_BIT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic              dev_ready,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_rd,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              reg_wr,
    output logic [DATA_W-1:0] reg_wdata
);
    logic              sclk_s, cs_n_s, mosi_s;
    logic              fall, byte_valid, tx_load;
    logic [7:0]        rx_byte;
    logic [IDX_W-1:0]  byte_idx;
    logic [DATA_W-1:0] tx_word;

    spireg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst),
        .sclk_in(spi_sclk), .cs_n_in(spi_cs_n), .mosi_in(spi_mosi),
        .sclk_s(sclk_s), .cs_n_s(cs_n_s), .mosi_s(mosi_s)
    );

    spireg_rx u_rx (
        .clk(clk), .rst(rst),
        .sclk_s(sclk_s), .cs_n_s(cs_n_s), .mosi_s(mosi_s),
        .fall(fall), .byte_valid(byte_valid),
        .rx_byte(rx_byte), .byte_idx(byte_idx)
    );

    spireg_ctrl #(
        .TEST_ADDR(TEST_ADDR), .CFG_ADDR(CFG_ADDR),
        .TEST_WORD(TEST_WORD), .READY_BIT(READY_BIT)
    ) u_ctrl (
        .clk(clk), .rst(rst), .cs_n_s(cs_n_s),
        .byte_valid(byte_valid), .rx_byte(rx_byte), .byte_idx(byte_idx),
        .ready(dev_ready), .reg_rdata(reg_rdata),
        .reg_addr(reg_addr), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .tx_load(tx_load), .tx_word(tx_word)
    );

    spireg_tx u_tx (
        .clk(clk), .rst(rst), .cs_n_s(cs_n_s), .fall(fall),
        .load(tx_load), .load_word(tx_word), .miso(spi_miso)
    );

    assert_load_in_frame_R2: assert property (@(posedge clk) disable iff (rst)
        tx_load |-> !cs_n_s);
endmodule

// File: tb/spireg_slave_test.sv
module spireg_slave_test;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        spi_sclk = 1'b0;
    logic        spi_cs_n = 1'b1;
    logic        spi_mosi = 1'b0;
    logic        spi_miso;
    logic        dev_ready = 1'b0;
    logic [15:0] reg_addr;
    logic        reg_rd;
    logic [31:0] reg_rdata = '0;
    logic        reg_wr;
    logic [31:0] reg_wdata;

    int tests = 0;
    int fails = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    logic [15:0] last_rd_addr = '0;
    logic [15:0] last_wr_addr = '0;
    logic [31:0] last_wr_data = '0;

    logic [7:0] tx_buf [0:8];
    logic [7:0] rx_buf [0:8];

    always #2 clk = ~clk;

    spireg_slave uut (
        .clk(clk), .rst(rst),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .dev_ready(dev_ready),
        .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata)
    );

    function automatic logic [31:0] model(logic [15:0] a);
        return {a, ~a} ^ 32'h5A3C_96E1;
    endfunction

    function automatic logic is_fixed(logic [15:0] a);
        return (a == 16'h0064) || (a == 16'h0074);
    endfunction

    // Internal-port responder: read data one cycle after the request.
    always @(posedge clk) begin
        if (reg_rd) begin
            reg_rdata    <= model(reg_addr);
            rd_cnt       <= rd_cnt + 1;
            last_rd_addr <= reg_addr;
        end
        if (reg_wr) begin
            wr_cnt       <= wr_cnt + 1;
            last_wr_addr <= reg_addr;
            last_wr_data <= reg_wdata;
        end
    end

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer_byte(input logic [7:0] tx, output logic [7:0] rx);
        for (int b = 7; b >= 0; b--) begin
            spi_mosi = tx[b];
            wait_clks(HALF);
            rx[b]    = spi_miso;
            spi_sclk = 1'b1;
            wait_clks(HALF);
            spi_sclk = 1'b0;
        end
    endtask

    task automatic run_frame(input int n);
        logic [7:0] r;
        spi_cs_n = 1'b0;
        wait_clks(HALF);
        for (int i = 0; i < n; i++) begin
            xfer_byte(tx_buf[i], r);
            rx_buf[i] = r;
        end
        wait_clks(HALF);
        spi_cs_n = 1'b1;
        wait_clks(4 * HALF);
    endtask

    task automatic spi_read(input logic [15:0] a, input int n, output logic [31:0] w);
        tx_buf[0] = 8'h03; tx_buf[1] = a[15:8]; tx_buf[2] = a[7:0];
        for (int i = 3; i < 9; i++) tx_buf[i] = 8'h00;
        run_frame(n);
        w = {rx_buf[6], rx_buf[5], rx_buf[4], rx_buf[3]};
    endtask

    task automatic spi_write(input logic [15:0] a, input logic [31:0] d, input int n);
        tx_buf[0] = 8'h02; tx_buf[1] = a[15:8]; tx_buf[2] = a[7:0];
        tx_buf[3] = d[7:0]; tx_buf[4] = d[15:8];
        tx_buf[5] = d[23:16]; tx_buf[6] = d[31:24];
        tx_buf[7] = 8'hC3; tx_buf[8] = 8'h3C;
        run_frame(n);
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] w;
        logic [15:0] a;
        logic [31:0] d;
        int          rc, wc;
        void'($urandom(32'd20240611));

        wait_clks(5);
        rst = 1'b0;
        wait_clks(2);
        // R1: reset state
        check("R1", "miso", {31'b0, spi_miso}, 32'd0);
        check("R1", "reg_rd", {31'b0, reg_rd}, 32'd0);
        check("R1", "reg_wr", {31'b0, reg_wr}, 32'd0);

        // R3: test word, no forwarding
        rc = rd_cnt;
        spi_read(16'h0064, 7, w);
        check("R3", "test word", w, 32'h8765_4321);
        check("R3", "no reg_rd", rd_cnt - rc, 0);

        // R11: idle miso low after a frame that shifted ones
        check("R11", "idle miso", {31'b0, spi_miso}, 32'd0);

        // R4: ready bit both ways
        dev_ready = 1'b0;
        spi_read(16'h0074, 7, w);
        check("R4", "cfg not ready", w, 32'h0000_0000);
        dev_ready = 1'b1;
        spi_read(16'h0074, 7, w);
        check("R4", "cfg ready", w, 32'h0800_0000);
        check("R4", "no reg_rd", rd_cnt - rc, 0);

        // R5 / R2: random forwarded reads
        for (int i = 0; i < 12; i++) begin
            a = 16'($urandom);
            if (is_fixed(a)) a = a ^ 16'h0100;
            rc = rd_cnt;
            spi_read(a, 7, w);
            check("R5", "rd pulses", rd_cnt - rc, 1);
            check("R5", "rd addr", {16'b0, last_rd_addr}, {16'b0, a});
            check("R2", "read data", w, model(a));
        end

        // R6: random writes
        for (int i = 0; i < 12; i++) begin
            a = 16'($urandom);
            if (is_fixed(a)) a = a ^ 16'h0200;
            d = $urandom;
            wc = wr_cnt;
            spi_write(a, d, 7);
            check("R6", "wr pulses", wr_cnt - wc, 1);
            check("R6", "wr addr", {16'b0, last_wr_addr}, {16'b0, a});
            check("R6", "wr data", last_wr_data, d);
        end

        // R7: writes to local addresses dropped
        wc = wr_cnt;
        spi_write(16'h0064, 32'hDEAD_BEEF, 7);
        spi_write(16'h0074, 32'h1234_5678, 7);
        check("R7", "no reg_wr", wr_cnt - wc, 0);
        spi_read(16'h0064, 7, w);
        check("R7", "test word kept", w, 32'h8765_4321);

        // R8: unknown opcode
        rc = rd_cnt; wc = wr_cnt;
        tx_buf[0] = 8'hA5;
        for (int i = 1; i < 9; i++) tx_buf[i] = 8'hFF;
        run_frame(7);
        check("R8", "no strobes", (rd_cnt - rc) + (wr_cnt - wc), 0);
        check("R8", "miso silent", {rx_buf[3], rx_buf[4], rx_buf[5], rx_buf[6]}, 32'd0);

        // R9: aborted write then a clean one
        wc = wr_cnt;
        spi_write(16'h0A5A, 32'hCAFE_F00D, 5);
        check("R9", "abort no wr", wr_cnt - wc, 0);
        spi_write(16'h1357, 32'h0BAD_CAFE, 7);
        check("R9", "fresh frame wr", wr_cnt - wc, 1);
        check("R9", "fresh data", last_wr_data, 32'h0BAD_CAFE);
        check("R9", "fresh addr", {16'b0, last_wr_addr}, 32'h0000_1357);

        // R10: extra bytes ignored
        wc = wr_cnt;
        spi_write(16'h2468, 32'h5555_AAAA, 9);
        check("R10", "single wr", wr_cnt - wc, 1);
        check("R10", "data", last_wr_data, 32'h5555_AAAA);
        rc = rd_cnt;
        spi_read(16'h0064, 9, w);
        check("R10", "read word", w, 32'h8765_4321);
        check("R10", "trailing bytes", {16'b0, rx_buf[7], rx_buf[8]}, 32'd0);
        check("R10", "no reg_rd", rd_cnt - rc, 0);

        wait_clks(4);
        check("R11", "final idle miso", {31'b0, spi_miso}, 32'd0);

        summary();
        $finish;
    end
endmodule